// File: doc/BRIEF.md
# Half-Duplex Serial Parameter Channel Master

This block runs the controller side of a slow parameter channel to a position encoder over one shared RS485 pair. Software-side logic first loads the request bytes, a command followed by any data, into a small request buffer. A start pulse then makes the block turn on the line driver, hold the line in the marking state for one bit time, and send the buffered bytes as asynchronous characters. It appends a checksum byte equal to the XOR of everything sent before it, and releases the driver as soon as the final stop bit has finished.

After sending, the block listens on the same pair. If no character begins within a response window, the exchange ends with the timeout flag. Otherwise every received character is stored in a reply buffer. The reply ends once the line has been silent for a set number of bit times. A reply is accepted only if every character is well formed, it holds at least two bytes, and the XOR of all its bytes, including the trailing checksum, is zero. A one-cycle done pulse marks the end of every exchange. The reply bytes can then be read by index.

The bit time, buffer depths, response window, silence window and synchronizer depth are parameters. The default bit time gives 9600 baud from a 125 MHz clock.

Top module: `enc_param_link`

## Requirements
- R1: While reset is held and after it is released, txd and de are 1 and 0 respectively, and busy, done, err and tmo are 0. rsp_cnt is 0.
- R2: Each transmitted character is one low start bit, eight data bits least significant first, an even parity bit, and one high stop bit. Every bit lasts CLK_DIV clock cycles. Even parity means the parity bit equals the XOR of the eight data bits.
- R3: A request frame is the buffered bytes in the order they were written, followed by one checksum byte equal to their XOR. Consecutive characters follow with no idle time between them. An empty buffer sends only the checksum byte 0x00.
- R4: de rises exactly CLK_DIV cycles before the first start bit begins. It stays high through the frame, and falls in the same cycle that the last stop bit's CLK_DIV cycles end. txd is never low while de is low.
- R5: Characters on rxd are collected only after de has fallen and before done. They are stored in arrival order, read as rsp_byte at index rsp_idx, and counted in rsp_cnt.
- R6: A reply ends when no character has begun for IDLE_BITS bit times after the last one. done then pulses for exactly one cycle. A well-formed reply leaves err and tmo at 0.
- R7: err is set if the XOR of all reply bytes, checksum included, is nonzero. err is also set if the reply has fewer than two bytes.
- R8: err is set if any reply character has a parity bit that breaks even parity or a stop bit sampled low.
- R9: If no start bit arrives within RESP_BITS bit times after de falls, done pulses exactly RESP_BITS*CLK_DIV cycles after de falls, with tmo set to 1 and err set to 0.
- R10: While busy, start and req_we have no effect. A req_we in the same cycle as an accepted start is dropped. Writes beyond REQ_DEPTH are dropped. The request buffer is empty once a frame has been sent.
- R11: Reply bytes beyond RSP_DEPTH are discarded. In that case rsp_cnt stays at RSP_DEPTH and err is set.
- R12: err and tmo keep their values after done until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_we | input | 1 | Append req_byte to the request buffer |
| req_byte | input | 8 | Request byte to append |
| start | input | 1 | Begin an exchange with the buffered request |
| busy | output | 1 | Exchange in progress |
| txd | output | 1 | Serial transmit data to the transceiver |
| de | output | 1 | Transceiver driver enable |
| rxd | input | 1 | Serial receive data from the transceiver |
| done | output | 1 | One-cycle pulse at the end of an exchange |
| err | output | 1 | Last reply was malformed |
| tmo | output | 1 | Last request got no reply |
| rsp_cnt | output | $clog2(RSP_DEPTH+1) | Reply bytes stored |
| rsp_idx | input | $clog2(RSP_DEPTH) | Reply buffer read index |
| rsp_byte | output | 8 | Reply byte at rsp_idx |

## Verification
Two events can meet in one cycle: a buffer write and an accepted start, or a new start and an exchange still in progress. Both collisions are provoked on purpose. A write is issued in the same clock as start. Then a write and a start are issued while the block waits for a reply. They are judged at the serial line: the first frame must hold only the earlier bytes with their checksum. The following exchange must send the bare checksum 0x00, which shows that no stray byte entered the buffer and no second frame was launched.

// File: rtl/epl_pkg.sv
package epl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SEND,
      ST_WAIT,
      ST_RECV
   } epl_state_e;

   localparam int CHAR_LAST_BIT = 10;

   function automatic logic even_par(input logic [7:0] b);
      return ^b;
   endfunction
endpackage

// File: rtl/epl_tx.sv
module epl_tx #(
   parameter int CLK_DIV = 13021
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] din,
   output logic       txd,
   output logic       idle,
   output logic       last_tick
);
   import epl_pkg::*;

   localparam int DW = $clog2(CLK_DIV);
   localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
   localparam logic [3:0]    BIT_LAST = 4'(CHAR_LAST_BIT);

   logic          busy_q;
   logic [10:0]   sh;
   logic [3:0]    bitn;
   logic [DW-1:0] div;

   generate
      if (CLK_DIV < 4) begin : g_bad_div
         $error("epl_tx: CLK_DIV must be at least 4");
      end
   endgenerate

   assign last_tick = busy_q && (div == DIV_LAST) && (bitn == BIT_LAST);
   assign idle      = !busy_q;
   assign txd       = busy_q ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sh     <= '1;
         bitn   <= '0;
         div    <= '0;
      end else if (go && (!busy_q || last_tick)) begin
         sh     <= {1'b1, even_par(din), din, 1'b0};
         busy_q <= 1'b1;
         bitn   <= '0;
         div    <= '0;
      end else if (busy_q) begin
         if (div == DIV_LAST) begin
            div <= '0;
            sh  <= {1'b1, sh[10:1]};
            if (bitn == BIT_LAST) busy_q <= 1'b0;
            else                  bitn   <= bitn + 1'b1;
         end else begin
            div <= div + 1'b1;
         end
      end
   end

   a_r2_stop_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bitn == BIT_LAST) |-> txd);
   a_r2_bit_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (bitn <= BIT_LAST));
endmodule

// File: rtl/epl_rx.sv
module epl_rx #(
   parameter int CLK_DIV     = 13021,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       rxd,
   output logic       active,
   output logic       vld,
   output logic [7:0] dout,
   output logic       bad
);
   import epl_pkg::*;

   localparam int DW = $clog2(CLK_DIV);
   localparam logic [DW-1:0] DIV_LAST  = DW'(CLK_DIV - 1);
   localparam logic [DW-1:0] HALF_LAST = DW'(CLK_DIV / 2 - 1);
   localparam logic [3:0]    BIT_LAST  = 4'(CHAR_LAST_BIT);

   logic [SYNC_STAGES-1:0] sq;
   logic                   rs, prev;
   logic [3:0]             bitn;
   logic [8:0]             sh;
   logic [DW-1:0]          div;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("epl_rx: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sq[0] <= 1'b1;
               else        sq[0] <= rxd;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sq[i] <= 1'b1;
               else        sq[i] <= sq[i-1];
         end
      end
   endgenerate

   assign rs = sq[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev   <= 1'b1;
         active <= 1'b0;
         vld    <= 1'b0;
         dout   <= '0;
         bad    <= 1'b0;
         bitn   <= '0;
         sh     <= '0;
         div    <= '0;
      end else begin
         prev <= rs;
         vld  <= 1'b0;
         if (!active) begin
            if (en && prev && !rs) begin
               active <= 1'b1;
               div    <= '0;
               bitn   <= '0;
            end
         end else if (div == ((bitn == 4'd0) ? HALF_LAST : DIV_LAST)) begin
            div  <= '0;
            bitn <= bitn + 1'b1;
            if (bitn == 4'd0) begin
               if (rs) active <= 1'b0;
            end else if (bitn < BIT_LAST) begin
               sh <= {rs, sh[8:1]};
            end else begin
               active <= 1'b0;
               vld    <= 1'b1;
               dout   <= sh[7:0];
               bad    <= (^sh) | !rs;
            end
         end else begin
            div <= div + 1'b1;
         end
      end
   end

   a_r8_rx_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (bitn <= BIT_LAST));
   a_r5_vld_ends_char: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> !active);
endmodule

// File: rtl/enc_param_link.sv
module enc_param_link #(
   parameter int CLK_DIV     = 13021,
   parameter int REQ_DEPTH   = 16,
   parameter int RSP_DEPTH   = 16,
   parameter int RESP_BITS   = 110,
   parameter int IDLE_BITS   = 22,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_we,
   input  logic [7:0]                   req_byte,
   input  logic                         start,
   output logic                         busy,
   output logic                         txd,
   output logic                         de,
   input  logic                         rxd,
   output logic                         done,
   output logic                         err,
   output logic                         tmo,
   output logic [$clog2(RSP_DEPTH+1)-1:0] rsp_cnt,
   input  logic [$clog2(RSP_DEPTH)-1:0]   rsp_idx,
   output logic [7:0]                   rsp_byte
);
   import epl_pkg::*;

   localparam int QW       = $clog2(REQ_DEPTH + 1);
   localparam int QA       = $clog2(REQ_DEPTH);
   localparam int RW       = $clog2(RSP_DEPTH + 1);
   localparam int AW       = $clog2(RSP_DEPTH);
   localparam int RESP_CYC = RESP_BITS * CLK_DIV;
   localparam int IDLE_CYC = IDLE_BITS * CLK_DIV;
   localparam int TMAX     = (RESP_CYC > IDLE_CYC) ? RESP_CYC : IDLE_CYC;
   localparam int TW       = $clog2(TMAX) + 1;
   localparam logic [TW-1:0] LEAD_LAST = TW'(CLK_DIV - 1);
   localparam logic [TW-1:0] RESP_LAST = TW'(RESP_CYC - 1);
   localparam logic [TW-1:0] IDLE_LAST = TW'(IDLE_CYC - 1);
   localparam logic [QW-1:0] REQ_FULL  = QW'(REQ_DEPTH);
   localparam logic [RW-1:0] RSP_FULL  = RW'(RSP_DEPTH);
   localparam logic [RW-1:0] RSP_MIN   = RW'(2);

   generate
      if (REQ_DEPTH < 2 || (REQ_DEPTH & (REQ_DEPTH - 1)) != 0) begin : g_bad_req
         $error("enc_param_link: REQ_DEPTH must be a power of two >= 2");
      end
      if (RSP_DEPTH < 2 || (RSP_DEPTH & (RSP_DEPTH - 1)) != 0) begin : g_bad_rsp
         $error("enc_param_link: RSP_DEPTH must be a power of two >= 2");
      end
      if (RESP_BITS < 1 || IDLE_BITS < 11) begin : g_bad_win
         $error("enc_param_link: windows too short");
      end
   endgenerate

   epl_state_e    st;
   logic [7:0]    req_mem [REQ_DEPTH];
   logic [7:0]    rsp_mem [RSP_DEPTH];
   logic [QW-1:0] req_n, idx;
   logic [RW-1:0] rsp_n;
   logic [7:0]    csum, rx_x, tx_byte, rx_dout;
   logic          rx_bad, ovf, err_q, tmo_q, done_q, de_q;
   logic [TW-1:0] tcnt;
   logic          tx_go, tx_idle, tx_last, rx_en, rx_act, rx_vld, rx_err;

   assign tx_byte = (idx == req_n) ? csum : req_mem[idx[QA-1:0]];
   assign tx_go   = ((st == ST_LEAD && tcnt == LEAD_LAST) || st == ST_SEND)
                    && (tx_idle || tx_last) && (idx <= req_n);
   assign rx_en   = (st == ST_WAIT) || (st == ST_RECV);

   epl_tx #(.CLK_DIV(CLK_DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .go(tx_go), .din(tx_byte),
      .txd(txd), .idle(tx_idle), .last_tick(tx_last)
   );

   epl_rx #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .rxd(rxd),
      .active(rx_act), .vld(rx_vld), .dout(rx_dout), .bad(rx_err)
   );

   always_ff @(posedge clk) begin
      if (st == ST_IDLE && !start && req_we && req_n < REQ_FULL)
         req_mem[req_n[QA-1:0]] <= req_byte;
      if (rx_vld && rsp_n < RSP_FULL)
         rsp_mem[rsp_n[AW-1:0]] <= rx_dout;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         req_n  <= '0;
         idx    <= '0;
         csum   <= '0;
         rsp_n  <= '0;
         rx_x   <= '0;
         rx_bad <= 1'b0;
         ovf    <= 1'b0;
         tcnt   <= '0;
         err_q  <= 1'b0;
         tmo_q  <= 1'b0;
         done_q <= 1'b0;
         de_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_LEAD;
                  de_q   <= 1'b1;
                  tcnt   <= '0;
                  idx    <= '0;
                  csum   <= '0;
                  err_q  <= 1'b0;
                  tmo_q  <= 1'b0;
                  rsp_n  <= '0;
                  rx_x   <= '0;
                  rx_bad <= 1'b0;
                  ovf    <= 1'b0;
               end else if (req_we && req_n < REQ_FULL) begin
                  req_n <= req_n + 1'b1;
               end
            end
            ST_LEAD: begin
               tcnt <= tcnt + 1'b1;
               if (tx_go) st <= ST_SEND;
            end
            ST_SEND: begin
               if (tx_last && idx > req_n) begin
                  de_q  <= 1'b0;
                  st    <= ST_WAIT;
                  tcnt  <= '0;
                  req_n <= '0;
               end
            end
            ST_WAIT: begin
               if (rx_act) begin
                  st   <= ST_RECV;
                  tcnt <= '0;
               end else if (tcnt == RESP_LAST) begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
                  tmo_q  <= 1'b1;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_RECV: begin
               if (rx_act || rx_vld) begin
                  tcnt <= '0;
               end else if (tcnt == IDLE_LAST) begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
                  err_q  <= rx_bad || ovf || (rsp_n < RSP_MIN) || (rx_x != 8'h00);
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
         if (tx_go) begin
            idx  <= idx + 1'b1;
            csum <= csum ^ tx_byte;
         end
         if (rx_vld) begin
            rx_x   <= rx_x ^ rx_dout;
            rx_bad <= rx_bad | rx_err;
            if (rsp_n == RSP_FULL) ovf   <= 1'b1;
            else                   rsp_n <= rsp_n + 1'b1;
         end
      end
   end

   assign busy     = (st != ST_IDLE);
   assign de       = de_q;
   assign done     = done_q;
   assign err      = err_q;
   assign tmo      = tmo_q;
   assign rsp_cnt  = rsp_n;
   assign rsp_byte = rsp_mem[rsp_idx];

   a_r4_tx_under_de: assert property (@(posedge clk) disable iff (!rst_n)
      !txd |-> de_q);
   a_r5_no_rx_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
      de_q |-> !rx_act);
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !(err_q && tmo_q));
   a_r10_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && req_we) |=> (req_n == '0));
   a_r11_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_n <= RSP_FULL);
endmodule

// File: tb/enc_param_link_bench.sv
module enc_param_link_bench;
   localparam int D        = 8;
   localparam int RSPD     = 8;
   localparam int RESP_B   = 44;
   localparam int IDLE_B   = 22;
   localparam int RESP_CYC = RESP_B * D;
   localparam int IDLE_CYC = IDLE_B * D;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_we = 1'b0;
   logic [7:0] req_byte = '0;
   logic       start = 1'b0;
   logic       rxd = 1'b1;
   logic [2:0] rsp_idx = '0;
   logic       busy, txd, de, done, err, tmo;
   logic [3:0] rsp_cnt;
   logic [7:0] rsp_byte;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic done_prev = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   enc_param_link #(
      .CLK_DIV(D), .REQ_DEPTH(8), .RSP_DEPTH(RSPD),
      .RESP_BITS(RESP_B), .IDLE_BITS(IDLE_B), .SYNC_STAGES(2)
   ) u_enc_param_link (
      .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_byte(req_byte),
      .start(start), .busy(busy), .txd(txd), .de(de), .rxd(rxd),
      .done(done), .err(err), .tmo(tmo), .rsp_cnt(rsp_cnt),
      .rsp_idx(rsp_idx), .rsp_byte(rsp_byte)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every-clock line model: R4 drive rule, R6 single-cycle done
   always @(negedge clk) begin
      if (rst_n) begin
         chk(txd || de, "R4 txd low without de", {31'b0, de}, 1);
         chk(!(done && done_prev), "R6 done longer than one cycle", {31'b0, done}, 0);
      end
      done_prev <= done;
   end

   task automatic wait_to(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      req_we = 1'b1; req_byte = b;
      @(negedge clk);
      req_we = 1'b0;
   endtask

   task automatic kick();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic expect_frame(input logic [7:0] pl[$], output int t_fall);
      logic [7:0]  fr[$];
      logic [7:0]  x;
      logic [10:0] bits;
      int t0, cs;
      x = 8'h00;
      fr = pl;
      foreach (pl[i]) x ^= pl[i];
      fr.push_back(x);
      while (de !== 1'b1) @(negedge clk);
      t0 = cyc;
      while (txd !== 1'b0) @(negedge clk);
      cs = cyc;
      chk(cs - t0 == D, "R4 lead time", cs - t0, D);
      foreach (fr[k]) begin
         if (k > 0) begin
            wait_to(cs);
            chk(txd == 1'b0, "R3 contiguous characters", {31'b0, txd}, 0);
         end
         for (int b = 0; b < 11; b++) begin
            wait_to(cs + b * D + D / 2);
            bits[b] = txd;
         end
         chk(bits[0] == 1'b0 && bits[10] == 1'b1, "R2 start/stop bits",
             {30'b0, bits[10], bits[0]}, 2);
         chk(bits[8:1] == fr[k], "R3 frame byte", bits[8:1], fr[k]);
         chk(bits[9] == ^fr[k], "R2 even parity", {31'b0, bits[9]}, {31'b0, ^fr[k]});
         cs += 11 * D;
      end
      wait_to(cs - 1);
      chk(de == 1'b1, "R4 de held to stop end", {31'b0, de}, 1);
      wait_to(cs);
      chk(de == 1'b0, "R4 de released", {31'b0, de}, 0);
      t_fall = cs;
   endtask

   task automatic drive_char(input logic [7:0] b, input bit flip_par, input bit low_stop);
      rxd = 1'b0;
      repeat (D) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (D) @(negedge clk);
      end
      rxd = (^b) ^ flip_par;
      repeat (D) @(negedge clk);
      rxd = !low_stop;
      repeat (D) @(negedge clk);
      rxd = 1'b1;
      repeat (D) @(negedge clk);
   endtask

   task automatic wait_done(output int t);
      while (done !== 1'b1) @(negedge clk);
      t = cyc;
   endtask

   task automatic exchange(input logic [7:0] req[$], input logic [7:0] rsp[$],
                           input int bad_par_at, input int bad_stop_at,
                           input bit exp_err, input string tag);
      int tf, tq, td;
      foreach (req[i]) push(req[i]);
      kick();
      expect_frame(req, tf);
      repeat (20) @(negedge clk);
      foreach (rsp[i]) drive_char(rsp[i], i == bad_par_at, i == bad_stop_at);
      tq = cyc;
      wait_done(td);
      chk(td >= tq + IDLE_CYC - 2 * D && td <= tq + IDLE_CYC, {"R6 silence end ", tag},
          td - tq, IDLE_CYC);
      chk(err == exp_err, {"err flag ", tag}, {31'b0, err}, {31'b0, exp_err});
      chk(tmo == 1'b0, {"R6 tmo clear ", tag}, {31'b0, tmo}, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] q[$];
      logic [7:0] r[$];
      int tf, td;

      // R1 reset
      repeat (3) @(negedge clk);
      chk(txd == 1'b1 && de == 1'b0, "R1 line in reset", {30'b0, txd, de}, 2);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, err, tmo} == 4'b0, "R1 flags after reset", {28'b0, busy, done, err, tmo}, 0);
      chk(rsp_cnt == 0 && txd && !de, "R1 count and line", rsp_cnt, 0);

      // R5 R6 good reply
      q = '{8'h12, 8'hA5, 8'h3C};
      r = '{8'h01, 8'h80, 8'hFF, 8'h7E};
      exchange(q, r, -1, -1, 1'b0, "R5 good");
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R6 done pulse ended", {30'b0, done, busy}, 0);
      chk(rsp_cnt == 4, "R5 reply count", rsp_cnt, 4);
      foreach (r[i]) begin
         rsp_idx = 3'(i);
         #1;
         chk(rsp_byte == r[i], "R5 reply byte", rsp_byte, r[i]);
      end

      // R7 checksum mismatch
      q = '{8'h55};
      r = '{8'h10, 8'h20, 8'h31};
      exchange(q, r, -1, -1, 1'b1, "R7 bad checksum");
      chk(rsp_cnt == 3, "R7 count", rsp_cnt, 3);

      // R7 short reply
      q = '{8'h00};
      r = '{8'h00};
      exchange(q, r, -1, -1, 1'b1, "R7 short reply");

      // R8 parity and stop errors
      q = '{8'h7E};
      r = '{8'h03, 8'h04, 8'h07};
      exchange(q, r, 1, -1, 1'b1, "R8 parity");
      exchange(q, r, -1, 0, 1'b1, "R8 stop");

      // R12 err cleared by next accepted start
      q = '{8'h09};
      push(8'h09);
      kick();
      chk(err == 1'b0, "R12 err cleared at start", {31'b0, err}, 0);
      chk(busy == 1'b1, "R10 busy after start", {31'b0, busy}, 1);

      // R9 response timeout
      expect_frame(q, tf);
      wait_done(td);
      chk(td - tf == RESP_CYC, "R9 timeout instant", td - tf, RESP_CYC);
      chk(tmo == 1'b1 && err == 1'b0, "R9 tmo set", {30'b0, tmo, err}, 2);
      repeat (40) @(negedge clk);
      chk(tmo == 1'b1, "R12 tmo held", {31'b0, tmo}, 1);

      // R10 write coinciding with start, and activity while busy
      push(8'hA1);
      push(8'hB2);
      req_we = 1'b1; req_byte = 8'hC3; start = 1'b1;
      @(negedge clk);
      req_we = 1'b0; start = 1'b0;
      chk(tmo == 1'b0, "R12 tmo cleared at start", {31'b0, tmo}, 0);
      q = '{8'hA1, 8'hB2};
      expect_frame(q, tf);
      repeat (10) @(negedge clk);
      req_we = 1'b1; req_byte = 8'hD4; start = 1'b1;
      @(negedge clk);
      req_we = 1'b0; start = 1'b0;
      repeat (D + 2) @(negedge clk);
      chk(de == 1'b0, "R10 start ignored while busy", {31'b0, de}, 0);
      wait_done(td);
      chk(td - tf == RESP_CYC && tmo, "R10 exchange unchanged", td - tf, RESP_CYC);
      @(negedge clk);
      kick();
      q = {};
      expect_frame(q, tf);
      wait_done(td);
      chk(tmo == 1'b1, "R10 empty buffer exchange", {31'b0, tmo}, 1);

      // R11 overflow
      q = '{8'h01};
      r = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h88};
      exchange(q, r, -1, -1, 1'b1, "R11 overflow");
      chk(rsp_cnt == RSPD, "R11 count capped", rsp_cnt, RSPD);
      rsp_idx = 3'd7;
      #1;
      chk(rsp_byte == 8'h88, "R11 last kept byte", rsp_byte, 8'h88);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule